// File: doc/BRIEF.md
# Prioritized Interrupt Selection Logic

This block decides, once per clock, whether a core with user, supervisor, hypervisor-encoded and machine privilege levels should take an interrupt, and which one. It receives the vector of pending interrupt lines and the vector of per-line enables. It also receives a per-line delegation mask, the two global enable bits (machine and supervisor) and the current privilege level. From these it forms the set of lines that may interrupt right now.

Lines whose delegation bit is clear answer to the machine-level gate. Lines whose delegation bit is set answer to the supervisor-level gate. Among the lines that pass their gate, the one with the lowest index wins. The result is registered: a take strobe, and a cause word that carries the winning index in its low bits and has its top bit set to mark it as an interrupt rather than an exception. The trap sequencer of the core consumes both outputs.

Top module: `irq_select`

## Requirements
- R1: While the synchronous reset `rst_i` is high at a rising edge, `take_o` becomes 0 and `cause_o` becomes all zeros.
- R2: A line is a candidate only when its bit is set in both `irq_pending_i` and `irq_enable_i`. A line that is pending but not enabled, or enabled but not pending, is never selected.
- R3: A candidate whose `deleg_i` bit is 0 passes when `priv_i` is U (0), S (1) or H (2), whatever `mach_ie_i` is. When `priv_i` is M (3), it passes only if `mach_ie_i` is 1.
- R4: A candidate whose `deleg_i` bit is 1 passes when `priv_i` is U (0), whatever `sup_ie_i` is. When `priv_i` is S (1), it passes only if `sup_ie_i` is 1. It never passes when `priv_i` is H (2) or M (3).
- R5: When several candidates pass, the one with the lowest bit index is reported, whichever gate each one passed.
- R6: When an interrupt is taken, `cause_o` holds the winning index in bits [4:0] and has bit 31 set; all other bits are 0.
- R7: When no candidate passes, `take_o` is 0 and `cause_o` is all zeros.
- R8: `take_o` and `cause_o` reflect the inputs sampled at the previous rising edge, with exactly one cycle of latency. They hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| irq_pending_i | input | 32 | Pending interrupt lines |
| irq_enable_i | input | 32 | Per-line enables |
| deleg_i | input | 32 | Per-line delegation to the supervisor gate |
| mach_ie_i | input | 1 | Global machine interrupt enable |
| sup_ie_i | input | 1 | Global supervisor interrupt enable |
| priv_i | input | 2 | Current privilege: U=0, S=1, H=2, M=3 |
| take_o | output | 1 | Registered take-interrupt strobe |
| cause_o | output | 32 | Registered cause: bit 31 set plus the winning index |

## Verification
Both results are due one rising edge after the inputs that cause them. The bench therefore drives each input set on a falling edge and samples one time unit after the next rising edge. To check latency, the bench changes the inputs on a falling edge and reads the outputs before the following rising edge; they must still hold the earlier answer. On the next edge they must show the new one. The reset check holds `rst_i` through a rising edge while a live interrupt sits on the inputs, and then samples after that edge.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    // Privilege encoding; the numeric order is used by the gates.
    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_H = 2'd2,
        PRIV_M = 2'd3
    } priv_e;

endpackage

// File: rtl/irq_gate.sv
module irq_gate
    import irq_sel_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] deleg_i,
    input  logic         mach_ie_i,
    input  logic         sup_ie_i,
    input  logic [1:0]   priv_i,
    output logic [N-1:0] live_o
);

    logic [N-1:0] cand;
    logic         mach_ok;
    logic         sup_ok;

    always_comb begin
        cand    = pend_i & en_i;
        // machine gate: open below machine level, or at machine with enable
        mach_ok = (priv_i != PRIV_M) || mach_ie_i;
        // supervisor gate: open at user level, or at supervisor with enable
        sup_ok  = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && sup_ie_i);
        live_o  = (cand & ~deleg_i & {N{mach_ok}})
                | (cand &  deleg_i & {N{sup_ok}});
    end

endmodule

// File: rtl/irq_lowest.sv
module irq_lowest #(
    parameter int N  = 32,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    logic [N-1:0] iso;

    // keep only the lowest set bit
    assign iso     = vec_i & (~vec_i + N'(1));
    assign found_o = |vec_i;

    function automatic logic [N-1:0] index_mask(input int b);
        logic [N-1:0] m;
        m = '0;
        for (int i = 0; i < N; i++) begin
            m[i] = ((i >> b) & 1) == 1;
        end
        return m;
    endfunction

    // one OR-reduction per index bit
    for (genvar b = 0; b < IW; b++) begin : g_enc
        assign idx_o[b] = |(iso & index_mask(b));
    end

endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_sel_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_IRQ = 32
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_IRQ-1:0] irq_pending_i,
    input  logic [NUM_IRQ-1:0] irq_enable_i,
    input  logic [NUM_IRQ-1:0] deleg_i,
    input  logic               mach_ie_i,
    input  logic               sup_ie_i,
    input  logic [1:0]         priv_i,
    output logic               take_o,
    output logic [XLEN-1:0]    cause_o
);

    localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    typedef struct packed {
        logic            take;
        logic [XLEN-1:0] cause;
    } sel_t;

    logic [NUM_IRQ-1:0] live;
    logic               found;
    logic [IW-1:0]      idx;
    sel_t               sel_d;
    sel_t               sel_q;

    irq_gate #(.N(NUM_IRQ)) u_gate (
        .pend_i    (irq_pending_i),
        .en_i      (irq_enable_i),
        .deleg_i   (deleg_i),
        .mach_ie_i (mach_ie_i),
        .sup_ie_i  (sup_ie_i),
        .priv_i    (priv_i),
        .live_o    (live)
    );

    irq_lowest #(.N(NUM_IRQ), .IW(IW)) u_low (
        .vec_i   (live),
        .found_o (found),
        .idx_o   (idx)
    );

    always_comb begin
        sel_d       = '0;
        sel_d.take  = found;
        if (found) begin
            sel_d.cause[XLEN-1] = 1'b1;
            sel_d.cause[IW-1:0] = idx;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign take_o  = sel_q.take;
    assign cause_o = sel_q.cause;

endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk
    import irq_sel_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_IRQ = 32
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic [NUM_IRQ-1:0] irq_pending_i,
    input logic [NUM_IRQ-1:0] irq_enable_i,
    input logic [NUM_IRQ-1:0] deleg_i,
    input logic               mach_ie_i,
    input logic [1:0]         priv_i,
    input logic               take_o,
    input logic [XLEN-1:0]    cause_o
);

    localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic [NUM_IRQ-1:0] cand_q;
    logic               mask_m_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cand_q   <= '0;
            mask_m_q <= 1'b0;
        end else begin
            cand_q   <= irq_pending_i & irq_enable_i;
            mask_m_q <= (priv_i == PRIV_M) && !mach_ie_i && (deleg_i == '0);
        end
    end

    // R7
    idle_cause_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !take_o |-> (cause_o == '0));

    // R6
    cause_msb_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |-> cause_o[XLEN-1]);

    // R2
    winner_is_cand_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |-> cand_q[cause_o[IW-1:0]]);

    // R2
    empty_no_take_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((irq_pending_i & irq_enable_i) == '0) |=> !take_o);

    // R3
    mach_masked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        mask_m_q |-> !take_o);

endmodule

bind irq_select irq_select_chk #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .irq_pending_i (irq_pending_i),
    .irq_enable_i  (irq_enable_i),
    .deleg_i       (deleg_i),
    .mach_ie_i     (mach_ie_i),
    .priv_i        (priv_i),
    .take_o        (take_o),
    .cause_o       (cause_o)
);

// File: tb/tb_irq_select.sv
module tb_irq_select;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] pend, en, dlg;
    logic        mie, sie;
    logic [1:0]  priv;
    logic        take;
    logic [31:0] cause;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    irq_select dut (
        .clk_i         (clk),
        .rst_i         (rst),
        .irq_pending_i (pend),
        .irq_enable_i  (en),
        .deleg_i       (dlg),
        .mach_ie_i     (mie),
        .sup_ie_i      (sie),
        .priv_i        (priv),
        .take_o        (take),
        .cause_o       (cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference outcome {take, cause} built from R2..R7
    function automatic logic [32:0] expect_of(logic [31:0] p, logic [31:0] e,
            logic [31:0] d, logic mi, logic si, logic [1:0] pr);
        logic [31:0] c, ok;
        logic mo, so;
        c  = p & e;
        mo = (pr != 2'd3) || mi;
        so = (pr == 2'd0) || (pr == 2'd1 && si);
        ok = '0;
        for (int i = 0; i < 32; i++) begin
            if (c[i] && ((!d[i] && mo) || (d[i] && so))) ok[i] = 1'b1;
        end
        for (int i = 0; i < 32; i++) begin
            if (ok[i]) return {1'b1, 32'h8000_0000 | 32'(i)};
        end
        return '0;
    endfunction

    task automatic check(string req, logic [32:0] exp);
        n_run++;
        if ({take, cause} !== exp) begin
            n_fail++;
            $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
                     req, take, cause, exp[32], exp[31:0]);
        end
    endtask

    task automatic drive(logic [31:0] p, logic [31:0] e, logic [31:0] d,
                         logic mi, logic si, logic [1:0] pr);
        @(negedge clk);
        pend = p; en = e; dlg = d; mie = mi; sie = si; priv = pr;
    endtask

    task automatic apply(string req, logic [31:0] p, logic [31:0] e,
                         logic [31:0] d, logic mi, logic si, logic [1:0] pr);
        drive(p, e, d, mi, si, pr);
        @(posedge clk); #1;
        check(req, expect_of(p, e, d, mi, si, pr));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1;
        pend = 32'h0000_0010; en = 32'hFFFF_FFFF; dlg = '0;
        mie = 1'b1; sie = 1'b1; priv = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset holds outputs at zero despite a live interrupt
        check("R1", 33'h0);
        @(negedge clk);
        rst = 1'b0;

        // R2: pending but disabled, enabled but not pending
        apply("R2", 32'h0000_0010, 32'h0000_0000, '0, 1, 1, 2'd0);
        apply("R2", 32'h0000_0000, 32'hFFFF_FFFF, '0, 1, 1, 2'd0);
        // R3: machine gate
        apply("R3", 32'h0000_0080, 32'hFFFF_FFFF, '0, 0, 1, 2'd3);
        apply("R3", 32'h0000_0080, 32'hFFFF_FFFF, '0, 1, 0, 2'd3);
        check("R3", {1'b1, 32'h8000_0007});
        apply("R3", 32'h0000_0080, 32'hFFFF_FFFF, '0, 0, 0, 2'd2);
        check("R3", {1'b1, 32'h8000_0007});
        apply("R3", 32'h0000_0080, 32'hFFFF_FFFF, '0, 0, 0, 2'd1);
        // R4: supervisor gate on delegated lines
        apply("R4", 32'h0000_0020, 32'hFFFF_FFFF, 32'h20, 1, 0, 2'd1);
        check("R4", 33'h0);
        apply("R4", 32'h0000_0020, 32'hFFFF_FFFF, 32'h20, 1, 1, 2'd1);
        apply("R4", 32'h0000_0020, 32'hFFFF_FFFF, 32'h20, 0, 0, 2'd0);
        check("R4", {1'b1, 32'h8000_0005});
        apply("R4", 32'h0000_0020, 32'hFFFF_FFFF, 32'h20, 1, 1, 2'd2);
        check("R4", 33'h0);
        apply("R4", 32'h0000_0020, 32'hFFFF_FFFF, 32'h20, 1, 1, 2'd3);
        check("R4", 33'h0);
        // R5: lowest index wins
        apply("R5", 32'h0000_0808, 32'hFFFF_FFFF, '0, 1, 1, 2'd3);
        check("R5", {1'b1, 32'h8000_0003});
        apply("R5", 32'h8000_0001, 32'hFFFF_FFFF, '0, 1, 1, 2'd0);
        // R5: lower delegated line blocked, higher machine line wins
        apply("R5", 32'h0000_0204, 32'hFFFF_FFFF, 32'h4, 1, 1, 2'd3);
        check("R5", {1'b1, 32'h8000_0009});
        // R6: top line encodes as index 31
        apply("R6", 32'h8000_0000, 32'hFFFF_FFFF, '0, 1, 1, 2'd0);
        check("R6", {1'b1, 32'h8000_001F});
        // R7: nothing passes
        apply("R7", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 2'd3);
        check("R7", 33'h0);

        // R8: one-cycle latency, outputs stable until the next edge
        apply("R8", 32'h0000_0100, 32'hFFFF_FFFF, '0, 1, 1, 2'd0);
        drive('0, '0, '0, 1, 1, 2'd0);
        #1;
        check("R8", {1'b1, 32'h8000_0008});
        @(posedge clk); #1;
        check("R8", 33'h0);

        // R1: mid-run reset clears a live result
        apply("R1", 32'h0000_0002, 32'hFFFF_FFFF, '0, 1, 1, 2'd0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R1", 33'h0);
        @(negedge clk); rst = 1'b0;

        // R5: random mix over all gates
        for (int k = 0; k < 3000; k++) begin
            apply("R5", $urandom & $urandom & $urandom, $urandom | $urandom,
                  $urandom, 1'($urandom), 1'($urandom), 2'($urandom));
        end

        finish_run();
    end

endmodule